// File: doc/BRIEF.md
# Serial Bit-Stream Writer

This block turns bytes into a slow, software-style serial stream on two pins of an 8-bit general-purpose output port. A byte arrives on a valid/ready interface. The block then walks through its bits one at a time. For each bit it pulls the clock line low, presents the bit on the data line, holds it for a guaranteed setup window, and then raises the clock. Both lines are picked at run time by one-hot masks held in a configuration word, and the bit order can be chosen there as well.

Pins outside both masks pass the port's shadow output value through unchanged, so other users of the port are unaffected. A configuration is refused unless each mask hits at least one pin whose output enable is set when the word is written. A byte offered while no valid configuration is held is taken and discarded, and a sticky error flag records the loss.

Top module: `serial_bit_writer`

## Requirements
- R1: A configuration write (`cfgWe` high on a clock edge while not busy) loads the clock mask from `cfgWord[7:0]`, the data mask from `cfgWord[15:8]` and the MSB-first flag from `cfgWord[16]`. A write made while busy is ignored, and the byte in flight and later bytes keep the old masks.
- R2: A written configuration is valid only if the clock mask ANDed with `outEnable` is nonzero and the data mask ANDed with `outEnable` is nonzero, both taken at the time of the write. A zero mask is therefore invalid. After reset the configuration is invalid.
- R3: Each accepted byte is sent as 8 bits: bit 7 first down to bit 0 when the MSB-first flag is 1, and bit 0 first up to bit 7 when it is 0.
- R4: Each bit takes LOW_CYC+SETUP_CYC+HIGH_CYC cycles. The clock falls at the start of the bit, the data changes LOW_CYC cycles later, and the clock rises SETUP_CYC cycles after that. The data line changes only while the clock is low.
- R5: The data value seen at each clock rise equals the value on the data line in the cycle before the rise (at least one full cycle of setup, 10 ns at 100 MHz).
- R6: With a valid configuration, pins in the clock mask show the clock level, and pins in the data mask but not in the clock mask show the data level. All other pins show `shadowOut`. With an invalid configuration, `portOut` equals `shadowOut`. When idle the clock level is high.
- R7: `inReady` drops in the cycle after a byte is accepted and returns exactly 8×(LOW_CYC+SETUP_CYC+HIGH_CYC) cycles after the accepting edge. `busy` is always the inverse of `inReady`.
- R8: A byte offered while the configuration is invalid is accepted (`inReady` stays high), causes no pin activity, and sets `cfgErr`. `cfgErr` stays set through invalid configuration writes and is cleared by a valid one.
- R9: After reset, `inReady`=1, `busy`=0, `cfgErr`=0 and `portOut` equals `shadowOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWord | input | 17 | Configuration word: clock mask, data mask, MSB-first flag |
| outEnable | input | 8 | Current output enables of the port, sampled on a configuration write |
| shadowOut | input | 8 | Shadow output values for pins not used by the stream |
| inValid | input | 1 | Byte offered |
| inData | input | 8 | Byte to send |
| inReady | output | 1 | Block can take a byte |
| portOut | output | 8 | Port output value |
| busy | output | 1 | Byte being shifted out |
| cfgErr | output | 1 | Sticky flag: a byte was dropped for lack of a valid configuration |

## Verification
A wrong phase counter or state shows up within one bit period. The clock rise moves away from its slot in the bit, and the 8-rise count or the return of `inReady` lands on the wrong cycle. A wrong shift direction or a stale shift register shows up as a wrong assembled byte once the eighth rise has been seen, about 32 cycles after acceptance. A wrong configuration or error register shows up at once as pin activity, or the lack of it, on `portOut` and as the level of `cfgErr` on the next sample after the write or the offered byte.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_SETUP, ST_HIGH} sbw_state_e;

  // Per-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic load;     // latch a new byte
    logic drop;     // byte discarded, no valid configuration
    logic clkFall;  // drive the clock line low
    logic drive;    // present the next bit on the data line
    logic clkRise;  // drive the clock line high
  } sbw_strobe_t;
endpackage

// File: rtl/sbw_ctrl.sv
module sbw_ctrl
  import sbw_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LOW_CYC   = 1,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        cfgValid,
  output logic        inReady,
  output logic        busy,
  output sbw_strobe_t strb
);
  localparam int MAX_CYC = (LOW_CYC > SETUP_CYC)
                         ? ((LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC)
                         : ((SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LOW_LD   = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LD  = CNT_W'(HIGH_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  sbw_state_e       state;
  logic [CNT_W-1:0] phaseCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             accept, phaseDone, lastBit;

  always_comb begin
    accept       = inValid && (state == ST_IDLE);
    phaseDone    = (phaseCnt == '0);
    lastBit      = (bitIdx == LAST_BIT);
    strb.load    = accept && cfgValid;
    strb.drop    = accept && !cfgValid;
    strb.drive   = (state == ST_LOW) && phaseDone;
    strb.clkRise = (state == ST_SETUP) && phaseDone;
    strb.clkFall = strb.load || ((state == ST_HIGH) && phaseDone && !lastBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitIdx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strb.load) begin
          state    <= ST_LOW;
          phaseCnt <= LOW_LD;
          bitIdx   <= '0;
        end
        ST_LOW: if (phaseDone) begin
          state    <= ST_SETUP;
          phaseCnt <= SETUP_LD;
        end else phaseCnt <= phaseCnt - 1'b1;
        ST_SETUP: if (phaseDone) begin
          state    <= ST_HIGH;
          phaseCnt <= HIGH_LD;
        end else phaseCnt <= phaseCnt - 1'b1;
        ST_HIGH: if (phaseDone) begin
          if (lastBit) state <= ST_IDLE;
          else begin
            state    <= ST_LOW;
            phaseCnt <= LOW_LD;
            bitIdx   <= bitIdx + 1'b1;
          end
        end else phaseCnt <= phaseCnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign inReady = (state == ST_IDLE);
  assign busy    = !inReady;
endmodule

// File: rtl/sbw_datapath.sv
module sbw_datapath
  import sbw_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2*PORT_W:0] cfgWord,
  input  logic [PORT_W-1:0] outEnable,
  input  logic [PORT_W-1:0] shadowOut,
  input  logic [DATA_W-1:0] inData,
  input  logic              busy,
  input  sbw_strobe_t       strb,
  output logic              cfgValid,
  output logic              cfgErr,
  output logic              clkLvl,
  output logic              dataLvl,
  output logic [PORT_W-1:0] portOut
);
  logic [PORT_W-1:0] clkMask, dataMask, newClk, newData;
  logic              msbFirst, newOk, nextBit;
  logic [DATA_W-1:0] shiftReg;

  assign newClk  = cfgWord[PORT_W-1:0];
  assign newData = cfgWord[2*PORT_W-1:PORT_W];
  // A zero mask can never overlap the enables, so one test per mask suffices
  assign newOk   = (|(newClk & outEnable)) && (|(newData & outEnable));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkMask  <= '0;
      dataMask <= '0;
      msbFirst <= 1'b0;
      cfgValid <= 1'b0;
      cfgErr   <= 1'b0;
    end else begin
      if (strb.drop) cfgErr <= 1'b1;
      if (cfgWe && !busy) begin
        clkMask  <= newClk;
        dataMask <= newData;
        msbFirst <= cfgWord[2*PORT_W];
        cfgValid <= newOk;
        if (newOk) cfgErr <= 1'b0;
      end
    end
  end

  assign nextBit = msbFirst ? shiftReg[DATA_W-1] : shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      clkLvl   <= 1'b1;
      dataLvl  <= 1'b0;
    end else begin
      if (strb.load) shiftReg <= inData;
      else if (strb.drive)
        shiftReg <= msbFirst ? (shiftReg << 1) : (shiftReg >> 1);
      if (strb.drive)   dataLvl <= nextBit;
      if (strb.clkFall) clkLvl  <= 1'b0;
      else if (strb.clkRise) clkLvl <= 1'b1;
    end
  end

  // Per-pin merge: clock mask first, then data mask, then shadow value
  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    assign portOut[p] = !cfgValid    ? shadowOut[p] :
                        clkMask[p]  ? clkLvl       :
                        dataMask[p] ? dataLvl      : shadowOut[p];
  end
endmodule

// File: rtl/serial_bit_writer.sv
module serial_bit_writer
  import sbw_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int DATA_W    = 8,
  parameter int LOW_CYC   = 1,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2*PORT_W:0] cfgWord,
  input  logic [PORT_W-1:0] outEnable,
  input  logic [PORT_W-1:0] shadowOut,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic [PORT_W-1:0] portOut,
  output logic              busy,
  output logic              cfgErr
);
  sbw_strobe_t strb;
  logic        cfgValid, clkLvl, dataLvl;

  sbw_ctrl #(
    .DATA_W(DATA_W), .LOW_CYC(LOW_CYC), .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .cfgValid(cfgValid),
    .inReady(inReady), .busy(busy), .strb(strb)
  );

  sbw_datapath #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWord(cfgWord),
    .outEnable(outEnable), .shadowOut(shadowOut), .inData(inData),
    .busy(busy), .strb(strb), .cfgValid(cfgValid), .cfgErr(cfgErr),
    .clkLvl(clkLvl), .dataLvl(dataLvl), .portOut(portOut)
  );
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker (
  input logic clk,
  input logic rstN,
  input logic cfgWe,
  input logic inValid,
  input logic inReady,
  input logic busy,
  input logic cfgErr,
  input logic cfgValid,
  input logic clkLvl,
  input logic dataLvl
);
  // R1: configuration cannot change while a byte is in flight
  a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy && cfgWe |=> $stable(cfgValid));

  // R4: data line moves only while the clock line is low
  a_r4_data_clk_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataLvl) |-> !clkLvl);

  // R5: data held across the cycle before a rising clock
  a_r5_setup: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkLvl) |-> $stable(dataLvl));

  // R6: clock idles high
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> clkLvl);

  // R7: accepted byte with valid configuration makes the block busy
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && cfgValid |=> busy);

  // R8: no activity without a valid configuration; error is sticky
  a_r8_no_activity: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |-> !busy);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr && !cfgWe |=> cfgErr);
endmodule

bind serial_bit_writer sbw_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .inValid(inValid), .inReady(inReady),
  .busy(busy), .cfgErr(cfgErr), .cfgValid(cfgValid), .clkLvl(clkLvl),
  .dataLvl(dataLvl)
);

// File: tb/tb_serial_bit_writer.sv
module tb_serial_bit_writer;
  localparam int LOWC = 1, SETC = 2, HIGHC = 1;
  localparam int P = LOWC + SETC + HIGHC;

  logic        clk = 1'b0, rstN = 1'b0, cfgWe = 1'b0, inValid = 1'b0;
  logic [16:0] cfgWord = '0;
  logic [7:0]  outEnable = '0, shadowOut = '0, inData = '0;
  logic        inReady, busy, cfgErr;
  logic [7:0]  portOut;
  int          testCount = 0, failCount = 0;

  always #5 clk = ~clk;

  serial_bit_writer #(.LOW_CYC(LOWC), .SETUP_CYC(SETC), .HIGH_CYC(HIGHC)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWord(cfgWord),
    .outEnable(outEnable), .shadowOut(shadowOut), .inValid(inValid),
    .inData(inData), .inReady(inReady), .portOut(portOut), .busy(busy),
    .cfgErr(cfgErr)
  );

  // {oe, shadow, byte, msbFirst, dataMask, clkMask}
  localparam logic [40:0] VECS [0:7] = '{
    {8'hFF, 8'hF0, 8'hA5, 1'b1, 8'h02, 8'h01},
    {8'hFF, 8'h0F, 8'hA5, 1'b0, 8'h02, 8'h01},
    {8'hC0, 8'h00, 8'h3C, 1'b1, 8'h40, 8'h80},
    {8'h14, 8'hFF, 8'h01, 1'b0, 8'h04, 8'h10},
    {8'hFF, 8'hAA, 8'h80, 1'b1, 8'h20, 8'h08},
    {8'h03, 8'h55, 8'hFF, 1'b0, 8'h01, 8'h02},
    {8'h05, 8'h00, 8'h00, 1'b1, 8'h0C, 8'h03},
    {8'hFF, 8'h3C, 8'h96, 1'b0, 8'h80, 8'h40}
  };

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] cm, input logic [7:0] dm, input logic msb);
    cfgWord = {msb, dm, cm};
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sendAndCapture(input logic [7:0] b, input logic [7:0] cm,
                                input logic [7:0] dm, input logic [7:0] sh,
                                input logic msb);
    logic [7:0] got = '0;
    int rises = 0, shadowBad = 0, readyBad = 0, setupBad = 0, timeBad = 0;
    logic prevClk = 1'b1, prevData = 1'b0, clkNow, dataNow;
    logic [7:0] keep = ~(cm | dm);
    check(inReady === 1'b1, "R7 ready before byte", 32'(inReady), 1);
    inData = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    for (int idx = 0; idx < 8 * P; idx++) begin
      clkNow  = ((portOut & cm) == cm);
      dataNow = |(portOut & dm & ~cm);
      if ((portOut & keep) != (sh & keep)) shadowBad++;
      if (inReady !== 1'b0 || busy !== 1'b1) readyBad++;
      if (prevClk && !clkNow && (idx % P) != 0) timeBad++;
      if (!prevClk && clkNow) begin
        if ((idx % P) != LOWC + SETC) timeBad++;
        if (dataNow != prevData) setupBad++;
        if (rises < 8) got[msb ? 7 - rises : rises] = dataNow;
        rises++;
      end
      if (clkNow && (dataNow != prevData) && idx != 0) timeBad++;
      prevClk = clkNow; prevData = dataNow;
      @(negedge clk);
    end
    check(got == b, "R3 byte bit order", 32'(got), 32'(b));
    check(rises == 8, "R4 eight clock rises", rises, 8);
    check(timeBad == 0, "R4 edge placement", timeBad, 0);
    check(setupBad == 0, "R5 data setup before rise", setupBad, 0);
    check(shadowBad == 0, "R6 unselected pins keep shadow", shadowBad, 0);
    check(readyBad == 0, "R7 ready low while shifting", readyBad, 0);
    check(inReady === 1'b1 && busy === 1'b0, "R7 ready returns on time",
          32'(inReady), 1);
    check((portOut & cm) == cm, "R6 clock idles high", 32'(portOut & cm), 32'(cm));
  endtask

  task automatic offerDropped(input logic [7:0] b, input logic [7:0] sh);
    int moved = 0;
    inData = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(inReady === 1'b1, "R8 dropped byte leaves ready high", 32'(inReady), 1);
    check(cfgErr === 1'b1, "R8 error flag set", 32'(cfgErr), 1);
    for (int i = 0; i < 2 * P; i++) begin
      if (portOut !== sh || busy !== 1'b0) moved++;
      @(negedge clk);
    end
    check(moved == 0, "R8 no pin activity", moved, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testCount++; failCount++;
    $display("FAIL R7 watchdog: actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    shadowOut = 8'h5A; outEnable = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(inReady === 1'b1 && busy === 1'b0, "R9 reset ready/busy", 32'(inReady), 1);
    check(cfgErr === 1'b0, "R9 reset error clear", 32'(cfgErr), 0);
    check(portOut === 8'h5A, "R9 reset port is shadow", 32'(portOut), 32'h5A);

    // R8: no configuration yet, byte dropped
    offerDropped(8'h33, 8'h5A);
    // R2: zero data mask is refused, error stays
    writeCfg(8'h01, 8'h00, 1'b1);
    check(cfgErr === 1'b1, "R8 error survives invalid write", 32'(cfgErr), 1);
    offerDropped(8'h44, 8'h5A);
    // R2: clock mask on a pin without output enable is refused
    outEnable = 8'hFE;
    writeCfg(8'h01, 8'h02, 1'b0);
    offerDropped(8'h55, 8'h5A);
    // R2/R8: valid write clears error
    outEnable = 8'hFF;
    writeCfg(8'h01, 8'h02, 1'b0);
    check(cfgErr === 1'b0, "R8 valid write clears error", 32'(cfgErr), 0);
    check(portOut[0] === 1'b1, "R6 clock pin idle high after config", 32'(portOut[0]), 1);

    // Table walk: R1, R3, R4, R5, R6, R7
    for (int v = 0; v < 8; v++) begin
      outEnable = VECS[v][40:33];
      shadowOut = VECS[v][32:25];
      writeCfg(VECS[v][7:0], VECS[v][15:8], VECS[v][16]);
      check(cfgErr === 1'b0, "R1 vector config accepted", 32'(cfgErr), 0);
      sendAndCapture(VECS[v][24:17], VECS[v][7:0], VECS[v][15:8],
                     VECS[v][32:25], VECS[v][16]);
    end

    // R1: configuration write during a byte is ignored
    outEnable = 8'hFF; shadowOut = 8'h00;
    writeCfg(8'h01, 8'h02, 1'b1);
    inData = 8'hC3; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    writeCfg(8'h10, 8'h20, 1'b0);
    while (!inReady) @(negedge clk);
    check(portOut[0] === 1'b1, "R1 old clock pin kept", 32'(portOut[0]), 1);
    check(portOut[4] === 1'b0, "R1 new clock pin not taken", 32'(portOut[4]), 0);
    sendAndCapture(8'h6E, 8'h01, 8'h02, 8'h00, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule